// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block follows the row-buffer state of one DRAM bank, as seen from the memory controller. It takes one access at a time. Each access carries a row, a column and a read/write flag. It compares the requested row with the row currently held in the bank's sense amplifiers and sorts the access into one of three classes. A **hit** means the row is already open. An **empty** access means no row is open. A **conflict** means a different row is open. It then runs only the phases that class needs: precharge, then activate, then column transfer. Each phase lasts a number of controller cycles set by a parameter and is timed by a down-counter. On the last cycle of the column phase the block raises a one-cycle completion pulse. With the pulse it reports the class, the column and the direction of the access that finished.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the row, column and direction stable while `req_valid` is high and `req_ready` is low. `req_ready` stays low from acceptance until the completion pulse. Under open-page policy, `req_ready` rises again in the completion cycle itself, so a waiting request is taken back-to-back. Under close-page policy (`CLOSE_PAGE`=1), the bank precharges on its own after each access and reopens the request side only when that precharge is over.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0, no phase indicator is high, no row is open, and the first access is classified empty.
- R2: During the `done` pulse, `done_class` carries the access class (2'b00 hit, 2'b01 empty, 2'b10 conflict), and `done_col`/`done_write` echo the column and direction of the completed request. Outside the pulse, `done_class` is 2'b00.
- R3: A hit runs only the column phase. Counting the cycle after the accepting edge as cycle 1, `done` is high in cycle `T_COL`.
- R4: An empty access runs the activate phase and then the column phase. `done` is high in cycle `T_ACT+T_COL`.
- R5: A conflict runs precharge, then activate, then column. `done` is high in cycle `T_PRE+T_ACT+T_COL`.
- R6: The bank keeps exactly one open row, namely the row of the last accepted access. Under open-page policy, a later access to that row is a hit and an access to any other row is a conflict, even after idle cycles.
- R7: `req_ready` is 0 from the cycle after acceptance until the `done` cycle, and `done` lasts one cycle.
- R8: Under open-page policy, `req_ready` is 1 in the `done` cycle. A request presented then is accepted on that edge and is classified against the row just served.
- R9: Under close-page policy, every access is empty. After `done`, `in_pre` is high for `T_PRE` cycles and `req_ready` returns in the cycle after that.
- R10: `in_pre`, `in_act` and `in_col` are never high together. Each one is high for exactly its phase length during the phases an access runs.
- R11: The read/write flag has no effect on class or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| req_write | input | 1 | 1 = write, 0 = read |
| done | output | 1 | One-cycle completion pulse |
| done_class | output | 2 | Class of completed access (00 hit, 01 empty, 10 conflict) |
| done_col | output | COL_W | Column of completed access |
| done_write | output | 1 | Direction of completed access |
| in_pre | output | 1 | Precharge phase running (requested or automatic) |
| in_act | output | 1 | Activate phase running |
| in_col | output | 1 | Column phase running |

## Verification
Under open-page policy, the completion of one access and the acceptance of the next fall in the same cycle. The acceptance must see the row just opened while the pulse still reports the old access's class and column. The bench holds `req_valid` high across every completion and sweeps all ordered pairs of rows back-to-back. Each latency, class and echoed column is judged against a bench-side model of the open row. Under close-page policy, the same collision is provoked with a waiting request. That request must not be taken until the automatic precharge has run its full length.

// File: rtl/bank_rowbuf_pkg.sv
package bank_rowbuf_pkg;
  typedef enum logic [1:0] {
    CLS_HIT      = 2'b00,
    CLS_EMPTY    = 2'b01,
    CLS_CONFLICT = 2'b10
  } acc_class_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_ACT,
    PH_COL,
    PH_AUTOPRE
  } phase_e;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R10
endmodule

// File: rtl/row_tracker.sv
module row_tracker
  import bank_rowbuf_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [ROW_W-1:0] req_row,
  input  logic             clear,
  output acc_class_e       cls
);
  logic             open_valid;
  logic [ROW_W-1:0] open_row;

  always_comb begin
    if (!open_valid)               cls = CLS_EMPTY;
    else if (open_row == req_row)  cls = CLS_HIT;
    else                           cls = CLS_CONFLICT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_valid <= 1'b0;
      open_row   <= '0;
    end else if (accept) begin
      open_valid <= 1'b1;
      open_row   <= req_row;
    end else if (clear) begin
      open_valid <= 1'b0;
    end
  end

  AST_OPEN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (open_valid && open_row == $past(req_row))); // R6
  AST_NO_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && clear)); // R9
endmodule

// File: rtl/bank_seq.sv
module bank_seq
  import bank_rowbuf_pkg::*;
#(
  parameter int T_PRE      = 16,
  parameter int T_ACT      = 16,
  parameter int T_COL      = 16,
  parameter bit CLOSE_PAGE = 1'b0,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  acc_class_e       cls,
  input  logic             zero,
  output logic             req_ready,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             done,
  output logic [1:0]       done_class,
  output logic             clear,
  output logic             in_pre,
  output logic             in_act,
  output logic             in_col
);
  localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(T_PRE - 1);
  localparam logic [CNT_W-1:0] LD_ACT = CNT_W'(T_ACT - 1);
  localparam logic [CNT_W-1:0] LD_COL = CNT_W'(T_COL - 1);

  phase_e     state, nxt;
  acc_class_e cls_q;

  assign done      = (state == PH_COL) && zero;
  assign req_ready = (state == PH_IDLE) || (!CLOSE_PAGE && done);
  assign accept    = req_valid && req_ready;
  assign clear     = (state == PH_AUTOPRE) && zero;
  assign in_pre    = (state == PH_PRE) || (state == PH_AUTOPRE);
  assign in_act    = (state == PH_ACT);
  assign in_col    = (state == PH_COL);
  assign done_class = done ? cls_q : CLS_HIT;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    if (accept) begin
      load = 1'b1;
      case (cls)
        CLS_HIT:   begin nxt = PH_COL; load_val = LD_COL; end
        CLS_EMPTY: begin nxt = PH_ACT; load_val = LD_ACT; end
        default:   begin nxt = PH_PRE; load_val = LD_PRE; end
      endcase
    end else if (zero) begin
      case (state)
        PH_PRE: begin nxt = PH_ACT; load = 1'b1; load_val = LD_ACT; end
        PH_ACT: begin nxt = PH_COL; load = 1'b1; load_val = LD_COL; end
        PH_COL: begin
          if (CLOSE_PAGE) begin
            nxt = PH_AUTOPRE; load = 1'b1; load_val = LD_PRE;
          end else begin
            nxt = PH_IDLE;
          end
        end
        PH_AUTOPRE: nxt = PH_IDLE;
        default:    nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cls_q <= CLS_EMPTY;
    end else begin
      state <= nxt;
      if (accept) cls_q <= cls;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done); // R7
  AST_CLASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_class != 2'b11)); // R2
  AST_CLOSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (CLOSE_PAGE && done) |-> (done_class == CLS_EMPTY)); // R9
  AST_CLOSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (CLOSE_PAGE && done) |=> (!req_ready && in_pre)); // R9
  AST_OPEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!CLOSE_PAGE && done) |-> req_ready); // R8
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_pre, in_act, in_col})); // R10
endmodule

// File: rtl/bank_rowbuf_ctrl.sv
module bank_rowbuf_ctrl
  import bank_rowbuf_pkg::*;
#(
  parameter int ROW_W      = 14,
  parameter int COL_W      = 10,
  parameter int T_PRE      = 16,
  parameter int T_ACT      = 16,
  parameter int T_COL      = 16,
  parameter bit CLOSE_PAGE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  output logic             done,
  output logic [1:0]       done_class,
  output logic [COL_W-1:0] done_col,
  output logic             done_write,
  output logic             in_pre,
  output logic             in_act,
  output logic             in_col
);
  localparam int T_PA  = (T_PRE > T_ACT) ? T_PRE : T_ACT;
  localparam int T_MAX = (T_PA > T_COL) ? T_PA : T_COL;
  localparam int CNT_W = $clog2(T_MAX + 1);

  acc_class_e       cls;
  logic             accept, load, zero, clear;
  logic [CNT_W-1:0] load_val;
  logic [COL_W-1:0] col_q;
  logic             write_q;

  row_tracker #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_row(req_row),
    .clear(clear), .cls(cls)
  );

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  bank_seq #(
    .T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL),
    .CLOSE_PAGE(CLOSE_PAGE), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cls(cls), .zero(zero),
    .req_ready(req_ready), .accept(accept), .load(load), .load_val(load_val),
    .done(done), .done_class(done_class), .clear(clear),
    .in_pre(in_pre), .in_act(in_act), .in_col(in_col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      col_q   <= req_col;
      write_q <= req_write;
    end
  end

  assign done_col   = done ? col_q : '0;
  assign done_write = done & write_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && T_COL > 1) |=> !req_ready); // R7
endmodule

// File: tb/bank_rowbuf_ctrl_test.sv
module bank_rowbuf_ctrl_test;
  localparam int CLK_P = 10;
  localparam int ROW_W = 2;
  localparam int COL_W = 3;
  localparam int TP = 3;
  localparam int TA = 2;
  localparam int TC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic [COL_W-1:0] col = '0;

  logic rdy_o, dn_o, dw_o, pre_o, act_o, colp_o;
  logic rdy_c, dn_c, dw_c, pre_c, act_c, colp_c;
  logic [1:0] cls_o, cls_c;
  logic [COL_W-1:0] dc_o, dc_c;

  always #(CLK_P/2) clk = ~clk;

  bank_rowbuf_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_PRE(TP), .T_ACT(TA),
    .T_COL(TC), .CLOSE_PAGE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(valid & ~sel), .req_ready(rdy_o),
    .req_row(row), .req_col(col), .req_write(wr), .done(dn_o),
    .done_class(cls_o), .done_col(dc_o), .done_write(dw_o),
    .in_pre(pre_o), .in_act(act_o), .in_col(colp_o));

  bank_rowbuf_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_PRE(TP), .T_ACT(TA),
    .T_COL(TC), .CLOSE_PAGE(1'b1)) uut_cp (
    .clk(clk), .rst_n(rst_n), .req_valid(valid & sel), .req_ready(rdy_c),
    .req_row(row), .req_col(col), .req_write(wr), .done(dn_c),
    .done_class(cls_c), .done_col(dc_c), .done_write(dw_c),
    .in_pre(pre_c), .in_act(act_c), .in_col(colp_c));

  wire rdy  = sel ? rdy_c : rdy_o;
  wire dn   = sel ? dn_c : dn_o;
  wire dw   = sel ? dw_c : dw_o;
  wire pre  = sel ? pre_c : pre_o;
  wire act  = sel ? act_c : act_o;
  wire colp = sel ? colp_c : colp_o;
  wire [1:0] dcls = sel ? cls_c : cls_o;
  wire [COL_W-1:0] dcol = sel ? dc_c : dc_o;

  int errors = 0;
  int checks = 0;
  bit m_open = 1'b0;
  int m_row = 0;

  task automatic check_eq(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic access(input int r, input int c, input bit w, input bit last);
    int exp_cls, exp_lat, n, npre, nact, ncol, bad_rdy, g, gpre;
    if (sel || !m_open) exp_cls = 1;
    else if (m_row == r) exp_cls = 0;
    else exp_cls = 2;
    exp_lat = (exp_cls == 0) ? TC : (exp_cls == 1) ? TA + TC : TP + TA + TC;
    row = ROW_W'(r); col = COL_W'(c); wr = w; valid = 1'b1;
    while (!rdy) @(negedge clk);
    m_open = 1'b1; m_row = r;
    n = 0; npre = 0; nact = 0; ncol = 0; bad_rdy = 0;
    do begin
      @(negedge clk);
      n++;
      if (pre) npre++;
      if (act) nact++;
      if (colp) ncol++;
      if (!dn && rdy) bad_rdy++;
    end while (!dn && n < 100);
    check_eq("R3 R4 R5 R11 latency to done", n, exp_lat);
    check_eq("R2 R6 done_class", int'(dcls), exp_cls);
    check_eq("R2 done_col", int'(dcol), c);
    check_eq("R2 done_write", int'(dw), int'(w));
    check_eq("R10 precharge cycles", npre, (exp_cls == 2) ? TP : 0);
    check_eq("R10 activate cycles", nact, (exp_cls == 0) ? 0 : TA);
    check_eq("R10 column cycles", ncol, TC);
    check_eq("R7 ready low while busy", bad_rdy, 0);
    if (sel) begin
      check_eq("R9 ready low at done", int'(rdy), 0);
      g = 0; gpre = 0;
      while (!rdy && g < 100) begin
        @(negedge clk);
        g++;
        if (pre) gpre++;
      end
      check_eq("R9 auto precharge gap", g, TP + 1);
      check_eq("R9 auto precharge cycles", gpre, TP);
      m_open = 1'b0;
      if (last) valid = 1'b0;
    end else begin
      check_eq("R8 ready in done cycle", int'(rdy), 1);
      if (last) begin
        valid = 1'b0;
        @(negedge clk);
        check_eq("R7 done one cycle", int'(dn), 0);
        check_eq("R8 ready after done", int'(rdy), 1);
      end
    end
  endtask

  initial begin
    repeat (CLK_P * 10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 ready after reset", int'(rdy_o), 1);
    check_eq("R1 ready after reset close", int'(rdy_c), 1);
    check_eq("R1 done low", int'(dn_o | dn_c), 0);
    check_eq("R1 phases idle", int'({pre_o, act_o, colp_o, pre_c, act_c, colp_c}), 0);
    // R1: first access is empty (model starts closed)
    access(1, 5, 1'b0, 1'b1);
    // R6 R8: all ordered row pairs back-to-back, direction varied (R11)
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        access(a, a + b, 1'((a + b) & 1), 1'b0);
        access(b, 7 - b, 1'(a & 1), (a == 3 && b == 3));
      end
    end
    // R6: open row survives idle cycles
    repeat (5) begin
      @(negedge clk);
      check_eq("R7 idle no done", int'(dn_o), 0);
      check_eq("R10 idle no phase", int'({pre_o, act_o, colp_o}), 0);
    end
    access(3, 2, 1'b1, 1'b0);
    access(0, 1, 1'b0, 1'b1);
    // R9: close-page mode, repeated and different rows
    sel = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      access(i / 2, i, 1'(i & 1), 1'b0);
    end
    access(2, 4, 1'b1, 1'b1);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule